// File: doc/BRIEF.md
# Effective Address Unit

This block turns a decoded addressing mode and its operand bytes into the memory address an 8-bit controller will use. A request carries the mode code, two operand bytes from the instruction stream, the X and Y index values, the address of the following instruction and a bit number decoded from the opcode. Modes that need no memory are resolved with one register stage. Indirect modes fetch a two-byte pointer, low byte first, through a byte-wide read port that has one cycle of latency, and only then produce the address.

Requests enter on a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable until that edge. `req_ready` is low while a pointer fetch is in progress, so a request raised then waits. There is no back-pressure on the result side. `done` pulses for one cycle when `ea`, `br_target`, `bit_idx` and `page_cross` carry a new result. Those outputs then hold until the next `done`.

Top module: `agu_core`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `mem_rd_en`, `ea`, `br_target`, `bit_idx` and `page_cross` are all 0.
- R2: Mode 0 (zero page) gives `ea` = {00, op0}. Mode 1 gives {00, (op0+X) mod 256} and mode 2 gives {00, (op0+Y) mod 256}. In all three, `page_cross` is 0.
- R3: Mode 3 gives `ea` = {op1, op0}. Modes 4 and 5 give ({op1, op0} + X) mod 65536 and ({op1, op0} + Y) mod 65536 respectively. `page_cross` is 1 exactly when the addition changes the high byte, and it is 0 for mode 3.
- R4: Mode 6 (pre-indexed indirect) reads the pointer at p = (op0+X) mod 256 and then at (p+1) mod 256, both in page 0. `ea` = {byte read second, byte read first}, and `page_cross` is 0.
- R5: Mode 7 (post-indexed indirect) reads the pointer at {00, op0} and then at {00, (op0+1) mod 256}. `ea` = (pointer + Y) mod 65536, and `page_cross` is 1 when that addition changes the pointer's high byte.
- R6: Mode 8 (jump indirect) reads the pointer at {op1, op0} and then at ({op1, op0}+1) mod 65536, with a full 16-bit carry. `ea` is the pointer read.
- R7: Mode 9 (relative) gives `ea` = `br_target` = (next address + sign-extended op0) mod 65536.
- R8: Modes 10 (bit, zero page) and 11 (bit test and branch) give `ea` = {00, op0} and `bit_idx` = `req_bit`. Mode 11 also gives `br_target` = next address + sign-extended op1. In every mode other than 9 and 11, `br_target` equals the request's next address. `bit_idx` is 0 except in modes 10 and 11.
- R9: Mode 12 (special-page jump) gives `ea` = {FF, op0}.
- R10: A non-indirect request gives `done` one cycle after its acceptance edge. An indirect request (modes 6 to 8) asserts `mem_rd_en` in the first and second cycles after acceptance, at the low and then the high pointer address, and gives `done` in the fourth cycle. `done` lasts one cycle per request.
- R11: `req_ready` is 0 during the three cycles of a pointer fetch, and a request held during that time is taken only when `req_ready` returns. Between `done` pulses, `ea`, `br_target`, `bit_idx` and `page_cross` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_mode | input | 4 | Addressing mode code (0 to 12) |
| req_op0 | input | 8 | First operand byte |
| req_op1 | input | 8 | Second operand byte |
| req_x | input | 8 | X index value |
| req_y | input | 8 | Y index value |
| req_pc | input | 16 | Address of the following instruction |
| req_bit | input | 3 | Bit number for the bit modes |
| mem_rd_en | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| ea | output | 16 | Effective address |
| br_target | output | 16 | Branch target |
| bit_idx | output | 3 | Extracted bit number |
| page_cross | output | 1 | Indexed addition carried into the high byte |
| done | output | 1 | One-cycle strobe: new result on the outputs |

## Verification
Two events can share a cycle. One is the `done` pulse that finishes a request. The other is the acceptance edge of the next request, because `req_ready` is already high in the cycle where `done` rises. The bench provokes this with back-to-back direct requests, and with requests held valid while a pointer fetch is still running. A behavioural model advances one state per clock and predicts `req_ready`, `done`, the read address and every result field each cycle. It catches a dropped, doubled or late strobe, and a request taken too early or twice.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_ZP     = 4'd0,
    AM_ZPX    = 4'd1,
    AM_ZPY    = 4'd2,
    AM_ABS    = 4'd3,
    AM_ABSX   = 4'd4,
    AM_ABSY   = 4'd5,
    AM_INDX   = 4'd6,
    AM_INDY   = 4'd7,
    AM_IND    = 4'd8,
    AM_REL    = 4'd9,
    AM_BITZP  = 4'd10,
    AM_BITREL = 4'd11,
    AM_SPJ    = 4'd12
  } am_e;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_RDLO,
    PS_RDHI,
    PS_FIN
  } ps_e;
endpackage

// File: rtl/agu_index_add.sv
module agu_index_add #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] base,
  input  logic [DW-1:0]   idx,
  input  logic            in_page,
  output logic [2*DW-1:0] sum,
  output logic            carry_out
);
  logic [DW:0]   lo_sum;
  logic [DW-1:0] hi;

  always_comb begin
    lo_sum = {1'b0, base[DW-1:0]} + {1'b0, idx};
    if (in_page) begin
      hi        = base[2*DW-1:DW];
      carry_out = 1'b0;
    end else begin
      hi        = base[2*DW-1:DW] + {{(DW-1){1'b0}}, lo_sum[DW]};
      carry_out = lo_sum[DW];
    end
    sum = {hi, lo_sum[DW-1:0]};
  end
endmodule

// File: rtl/agu_mode_calc.sv
module agu_mode_calc
  import agu_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = 3
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     op0,
  input  logic [DW-1:0]     op1,
  input  logic [DW-1:0]     xi,
  input  logic [DW-1:0]     yi,
  input  logic [2*DW-1:0]   pc,
  input  logic [BW-1:0]     bnum,
  output logic              is_ind,
  output logic [2*DW-1:0]   ptr_addr,
  output logic              ptr_in_page,
  output logic [DW-1:0]     post_idx,
  output logic [2*DW-1:0]   d_ea,
  output logic [2*DW-1:0]   d_br,
  output logic [BW-1:0]     d_bit,
  output logic              d_cross
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] add_base;
  logic [DW-1:0] add_idx;
  logic          add_page;
  logic [AW-1:0] add_sum;
  logic          add_carry;
  logic [DW-1:0] rel_off;
  logic [AW-1:0] rel_tgt;

  // one shared adder serves all indexed forms and the (zp,X) pointer sum
  agu_index_add #(.DW(DW)) u_idx_add (
    .base      (add_base),
    .idx       (add_idx),
    .in_page   (add_page),
    .sum       (add_sum),
    .carry_out (add_carry)
  );

  always_comb begin
    add_base    = {{DW{1'b0}}, op0};
    add_idx     = '0;
    add_page    = 1'b1;
    is_ind      = 1'b0;
    ptr_in_page = 1'b1;
    post_idx    = '0;
    rel_off     = op0;
    case (mode)
      AM_ZPX:    add_idx = xi;
      AM_ZPY:    add_idx = yi;
      AM_ABS:    begin add_base = {op1, op0}; add_page = 1'b0; end
      AM_ABSX:   begin add_base = {op1, op0}; add_page = 1'b0; add_idx = xi; end
      AM_ABSY:   begin add_base = {op1, op0}; add_page = 1'b0; add_idx = yi; end
      AM_INDX:   begin is_ind = 1'b1; add_idx = xi; end
      AM_INDY:   begin is_ind = 1'b1; post_idx = yi; end
      AM_IND:    begin is_ind = 1'b1; ptr_in_page = 1'b0; end
      AM_BITREL: rel_off = op1;
      default:   ;
    endcase
  end

  assign rel_tgt = pc + {{DW{rel_off[DW-1]}}, rel_off};

  always_comb begin
    d_ea     = add_sum;
    d_br     = pc;
    d_bit    = '0;
    d_cross  = add_carry;
    ptr_addr = add_sum;
    case (mode)
      AM_IND:    ptr_addr = {op1, op0};
      AM_REL:    begin d_ea = rel_tgt; d_br = rel_tgt; end
      AM_BITZP:  d_bit = bnum;
      AM_BITREL: begin d_bit = bnum; d_br = rel_tgt; end
      AM_SPJ:    d_ea = {{DW{1'b1}}, op0};
      default:   ;
    endcase
  end
endmodule

// File: rtl/agu_ptr_seq.sv
module agu_ptr_seq
  import agu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*DW-1:0] ptr_addr,
  input  logic            ptr_in_page,
  input  logic [DW-1:0]   rdata,
  output logic            idle,
  output logic            rd_en,
  output logic [2*DW-1:0] rd_addr,
  output logic            fin,
  output logic [2*DW-1:0] ptr_val
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  ps_e           state;
  logic [AW-1:0] base_q;
  logic          page_q;
  logic [DW-1:0] lo_q;
  logic [AW-1:0] next_addr;
  logic          next_carry;

  // second pointer byte: same page rule as the first
  agu_index_add #(.DW(DW)) u_inc (
    .base      (base_q),
    .idx       (ONE),
    .in_page   (page_q),
    .sum       (next_addr),
    .carry_out (next_carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PS_IDLE;
      base_q <= '0;
      page_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      case (state)
        PS_IDLE: if (start) begin
          base_q <= ptr_addr;
          page_q <= ptr_in_page;
          state  <= PS_RDLO;
        end
        PS_RDLO: state <= PS_RDHI;
        PS_RDHI: begin
          lo_q  <= rdata;
          state <= PS_FIN;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  assign idle    = (state == PS_IDLE);
  assign rd_en   = (state == PS_RDLO) || (state == PS_RDHI);
  assign rd_addr = (state == PS_RDHI) ? next_addr : base_q;
  assign fin     = (state == PS_FIN);
  assign ptr_val = {rdata, lo_q};
endmodule

// File: rtl/agu_core.sv
module agu_core
  import agu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int AW = 2 * DATA_W,
  localparam int BW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [DATA_W-1:0] req_op0,
  input  logic [DATA_W-1:0] req_op1,
  input  logic [DATA_W-1:0] req_x,
  input  logic [DATA_W-1:0] req_y,
  input  logic [AW-1:0]     req_pc,
  input  logic [BW-1:0]     req_bit,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [AW-1:0]     ea,
  output logic [AW-1:0]     br_target,
  output logic [BW-1:0]     bit_idx,
  output logic              page_cross,
  output logic              done
);
  logic              accept;
  logic              is_ind;
  logic [AW-1:0]     ptr_addr;
  logic              ptr_in_page;
  logic [DATA_W-1:0] post_idx;
  logic [AW-1:0]     d_ea;
  logic [AW-1:0]     d_br;
  logic [BW-1:0]     d_bit;
  logic              d_cross;
  logic              seq_idle;
  logic              seq_fin;
  logic [AW-1:0]     ptr_val;
  logic [AW-1:0]     ind_ea;
  logic              ind_cross;
  logic [DATA_W-1:0] pidx_q;
  logic [AW-1:0]     pc_q;
  logic [AW-1:0]     ea_q;
  logic [AW-1:0]     br_q;
  logic [BW-1:0]     bit_q;
  logic              cross_q;
  logic              done_q;

  assign req_ready = seq_idle;
  assign accept    = req_valid && req_ready;

  agu_mode_calc #(.DW(DATA_W), .BW(BW)) u_calc (
    .mode        (req_mode),
    .op0         (req_op0),
    .op1         (req_op1),
    .xi          (req_x),
    .yi          (req_y),
    .pc          (req_pc),
    .bnum        (req_bit),
    .is_ind      (is_ind),
    .ptr_addr    (ptr_addr),
    .ptr_in_page (ptr_in_page),
    .post_idx    (post_idx),
    .d_ea        (d_ea),
    .d_br        (d_br),
    .d_bit       (d_bit),
    .d_cross     (d_cross)
  );

  agu_ptr_seq #(.DW(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept && is_ind),
    .ptr_addr    (ptr_addr),
    .ptr_in_page (ptr_in_page),
    .rdata       (mem_rdata),
    .idle        (seq_idle),
    .rd_en       (mem_rd_en),
    .rd_addr     (mem_addr),
    .fin         (seq_fin),
    .ptr_val     (ptr_val)
  );

  // post-index on the fetched pointer (zero for modes without it)
  agu_index_add #(.DW(DATA_W)) u_post_add (
    .base      (ptr_val),
    .idx       (pidx_q),
    .in_page   (1'b0),
    .sum       (ind_ea),
    .carry_out (ind_cross)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pidx_q  <= '0;
      pc_q    <= '0;
      ea_q    <= '0;
      br_q    <= '0;
      bit_q   <= '0;
      cross_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pidx_q <= post_idx;
        pc_q   <= req_pc;
        if (!is_ind) begin
          ea_q    <= d_ea;
          br_q    <= d_br;
          bit_q   <= d_bit;
          cross_q <= d_cross;
          done_q  <= 1'b1;
        end
      end
      if (seq_fin) begin
        ea_q    <= ind_ea;
        br_q    <= pc_q;
        bit_q   <= '0;
        cross_q <= ind_cross;
        done_q  <= 1'b1;
      end
    end
  end

  assign ea         = ea_q;
  assign br_target  = br_q;
  assign bit_idx    = bit_q;
  assign page_cross = cross_q;
  assign done       = done_q;
endmodule

// File: rtl/agu_core_chk.sv
module agu_core_chk
  import agu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int AW = 2 * DATA_W,
  localparam int BW = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [MODE_W-1:0] req_mode,
  input logic              mem_rd_en,
  input logic [AW-1:0]     mem_addr,
  input logic [AW-1:0]     ea,
  input logic [AW-1:0]     br_target,
  input logic [BW-1:0]     bit_idx,
  input logic              page_cross,
  input logic              done
);
  logic [MODE_W-1:0] cap_mode;
  logic              cap_zp;
  logic              req_direct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_mode <= '0;
    else if (req_valid && req_ready) cap_mode <= req_mode;
  end

  assign cap_zp = (cap_mode == AM_ZP) || (cap_mode == AM_ZPX) || (cap_mode == AM_ZPY) ||
                  (cap_mode == AM_BITZP) || (cap_mode == AM_BITREL);
  assign req_direct = (req_mode != AM_INDX) && (req_mode != AM_INDY) && (req_mode != AM_IND);

  AST_RD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_en) |=> mem_rd_en); // R10
  AST_RD_TWO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && $past(mem_rd_en) |=> !mem_rd_en); // R10
  AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_direct |=> done); // R10
  AST_RD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready); // R11
  AST_ZP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done && cap_zp |-> ea[AW-1:DATA_W] == '0); // R2
  AST_ZP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && ((cap_mode == AM_INDX) || (cap_mode == AM_INDY)) |-> mem_addr[AW-1:DATA_W] == '0); // R4
  AST_SPJ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done && (cap_mode == AM_SPJ) |-> ea[AW-1:DATA_W] == '1); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea) && $stable(br_target) && $stable(bit_idx) && $stable(page_cross)); // R11
endmodule

bind agu_core agu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_mode   (req_mode),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .ea         (ea),
  .br_target  (br_target),
  .bit_idx    (bit_idx),
  .page_cross (page_cross),
  .done       (done)
);

// File: tb/agu_core_tb.sv
`timescale 1ns/1ps
module agu_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_op0 = '0, req_op1 = '0, req_x = '0, req_y = '0;
  logic [15:0] req_pc = '0;
  logic [2:0]  req_bit = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] ea, br_target;
  logic [2:0]  bit_idx;
  logic        page_cross, done;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  agu_core u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_op0(req_op0), .req_op1(req_op1), .req_x(req_x),
    .req_y(req_y), .req_pc(req_pc), .req_bit(req_bit), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ea(ea), .br_target(br_target),
    .bit_idx(bit_idx), .page_cross(page_cross), .done(done)
  );

  function automatic logic [7:0] mem_f(logic [15:0] a);
    return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_f(mem_addr);

  typedef struct {
    logic [15:0] ea, br, alo, ahi;
    logic [2:0]  bi;
    logic        cr, ind;
    string       tag;
  } res_t;

  function automatic res_t eval(logic [3:0] m, logic [7:0] o0, o1, xx, yy,
                                logic [15:0] pc, logic [2:0] bn);
    res_t r;
    logic [7:0]  z;
    logic [16:0] s;
    logic [15:0] p;
    r.ea = '0; r.br = pc; r.bi = '0; r.cr = 1'b0; r.ind = 1'b0;
    r.alo = '0; r.ahi = '0; r.tag = "R2";
    case (m)
      4'd1: begin z = o0 + xx; r.ea = {8'h00, z}; end
      4'd2: begin z = o0 + yy; r.ea = {8'h00, z}; end
      4'd3: begin r.ea = {o1, o0}; r.tag = "R3"; end
      4'd4, 4'd5: begin
        s = {1'b0, o1, o0} + {9'd0, (m == 4'd4) ? xx : yy};
        r.ea = s[15:0]; r.cr = (s[15:8] != o1); r.tag = "R3";
      end
      4'd6, 4'd7: begin
        z = (m == 4'd6) ? 8'(o0 + xx) : o0;
        r.ind = 1'b1; r.alo = {8'h00, z}; r.ahi = {8'h00, 8'(z + 8'd1)};
        p = {mem_f(r.ahi), mem_f(r.alo)};
        if (m == 4'd6) begin r.ea = p; r.tag = "R4"; end
        else begin
          s = {1'b0, p} + {9'd0, yy};
          r.ea = s[15:0]; r.cr = (s[15:8] != p[15:8]); r.tag = "R5";
        end
      end
      4'd8: begin
        r.ind = 1'b1; r.alo = {o1, o0}; r.ahi = 16'({o1, o0} + 16'd1);
        r.ea = {mem_f(r.ahi), mem_f(r.alo)}; r.tag = "R6";
      end
      4'd9: begin
        r.ea = pc + {{8{o0[7]}}, o0}; r.br = r.ea; r.tag = "R7";
      end
      4'd10: begin r.ea = {8'h00, o0}; r.bi = bn; r.tag = "R8"; end
      4'd11: begin
        r.ea = {8'h00, o0}; r.bi = bn; r.br = pc + {{8{o1[7]}}, o1}; r.tag = "R8";
      end
      4'd12: begin r.ea = {8'hFF, o0}; r.tag = "R9"; end
      default: r.ea = {8'h00, o0};
    endcase
    return r;
  endfunction

  // cycle-by-cycle reference model
  int          m_busy = 0;
  res_t        pend, cur;
  logic        e_done = 1'b0;

  initial begin
    cur.ea = '0; cur.br = '0; cur.bi = '0; cur.cr = 1'b0; cur.ind = 1'b0;
    cur.alo = '0; cur.ahi = '0; cur.tag = "R1";
    pend = cur;
  end

  always @(posedge clk) begin
    res_t r;
    if (!rst_n) begin
      m_busy = 0; e_done = 1'b0;
      cur.ea = '0; cur.br = '0; cur.bi = '0; cur.cr = 1'b0; cur.tag = "R1";
    end else begin
      e_done = 1'b0;
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin e_done = 1'b1; cur = pend; end
      end else if (req_valid) begin
        r = eval(req_mode, req_op0, req_op1, req_x, req_y, req_pc, req_bit);
        if (r.ind) begin m_busy = 3; pend = r; end
        else begin e_done = 1'b1; cur = r; end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string vt;
    if (rst_n && !finished) begin
      vectors++;
      vt = e_done ? cur.tag : "R11";
      chk("R11", "req_ready", {15'd0, req_ready}, {15'd0, m_busy == 0});
      chk("R10", "done", {15'd0, done}, {15'd0, e_done});
      chk("R10", "mem_rd_en", {15'd0, mem_rd_en}, {15'd0, (m_busy == 3) || (m_busy == 2)});
      if (m_busy == 3) chk(pend.tag, "mem_addr lo", mem_addr, pend.alo);
      if (m_busy == 2) chk(pend.tag, "mem_addr hi", mem_addr, pend.ahi);
      chk(vt, "ea", ea, cur.ea);
      chk(vt, "br_target", br_target, cur.br);
      chk(vt, "bit_idx", {13'd0, bit_idx}, {13'd0, cur.bi});
      chk(vt, "page_cross", {15'd0, page_cross}, {15'd0, cur.cr});
    end
  end

  task automatic send(input logic [3:0] m, input logic [7:0] a, b, xx, yy,
                      input logic [15:0] pc, input logic [2:0] bn);
    bit taken;
    req_mode = m; req_op0 = a; req_op1 = b; req_x = xx; req_y = yy;
    req_pc = pc; req_bit = bn; req_valid = 1'b1;
    do begin
      taken = req_ready;
      @(negedge clk);
    end while (!taken);
  endtask

  task automatic gap(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      miscompares++;
      $display("FAIL R10 watchdog actual=%0d expected=<100000 cycles", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    vectors++;
    chk("R1", "ready", {15'd0, req_ready}, 16'd1);
    chk("R1", "done", {15'd0, done}, 16'd0);
    chk("R1", "rd_en", {15'd0, mem_rd_en}, 16'd0);
    chk("R1", "ea", ea, 16'd0);
    chk("R1", "br", br_target, 16'd0);
    // directed: R2 page wrap, R3 cross/no cross and 16-bit wrap
    send(4'd0, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h8000, 3'd0);
    send(4'd1, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h8000, 3'd0);
    send(4'd2, 8'h80, 8'h00, 8'h00, 8'h80, 16'h8000, 3'd0);
    gap(1);
    send(4'd3, 8'h34, 8'h12, 8'h55, 8'h66, 16'h8000, 3'd0);
    send(4'd4, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h8000, 3'd0);
    send(4'd4, 8'h10, 8'h12, 8'h20, 8'h00, 16'h8000, 3'd0);
    send(4'd5, 8'hFF, 8'hFF, 8'h00, 8'h01, 16'h8000, 3'd0);
    // R4 pointer at $FF takes high byte from $00; R5 carry; R6 full carry
    send(4'd6, 8'hFE, 8'h00, 8'h01, 8'h00, 16'h8000, 3'd0);
    send(4'd1, 8'h01, 8'h00, 8'h01, 8'h00, 16'h8000, 3'd0);
    send(4'd7, 8'hFF, 8'h00, 8'h00, 8'hF0, 16'h8000, 3'd0);
    send(4'd7, 8'h40, 8'h00, 8'h00, 8'hFF, 16'h8000, 3'd0);
    send(4'd8, 8'hFF, 8'h10, 8'h00, 8'h00, 16'h8000, 3'd0);
    gap(2);
    // R7 backward and forward, R8 bit forms, R9 special page
    send(4'd9, 8'h80, 8'h00, 8'h00, 8'h00, 16'h0010, 3'd0);
    send(4'd9, 8'h7F, 8'h00, 8'h00, 8'h00, 16'hFFF0, 3'd0);
    send(4'd10, 8'h3A, 8'h00, 8'h00, 8'h00, 16'h1234, 3'd5);
    send(4'd11, 8'h3B, 8'hFE, 8'h00, 8'h00, 16'h1234, 3'd7);
    send(4'd12, 8'h42, 8'h99, 8'h00, 8'h00, 16'h1234, 3'd2);
    gap(3);
    // mixed stream, R10 and R11 handshake with random gaps
    for (int i = 0; i < 600; i++) begin
      send(4'($urandom_range(0, 12)), 8'($urandom), 8'($urandom), 8'($urandom),
           8'($urandom), 16'($urandom), 3'($urandom));
      if ($urandom_range(0, 2) == 0) gap($urandom_range(1, 3));
    end
    gap(6);
    summary();
  end
endmodule